// File: doc/BRIEF.md
# Two-Stage Watchdog with Selectable Reset

The block watches one bit of an external, free-running timebase counter. A two-bit period code picks which bit is watched, and so how many timebase ticks make one watchdog period. Each time the watched bit goes from 0 to 1, the period has expired, and the watchdog takes one step along a staged progression. That progression is held in the top two bits of a status register.

The first unserviced expiry only marks that a period went by. The second raises an interrupt, if the interrupt is enabled. The third requests a reset of the kind chosen in the control register. It also records that kind in the status register, and then the watchdog stops stepping. Software services the watchdog by writing ones to the status bits, which clears them and returns the progression to its start. The reset generator and the timebase counter are outside the block.

Top module: `wdg_top`

## Requirements
- R1: While and after reset, the status readback, the control readback, the interrupt and all three reset requests are zero.
- R2: Control bits 31:30 hold a period code c. The watched timebase bit is PER_LOG0-1+PER_STEP*c, so the period is 2^(PER_LOG0+PER_STEP*c) ticks. The defaults give 2^17, 2^21, 2^25 and 2^29. An expiry is the clock edge at which the watched bit is first sampled as 1 after being sampled as 0, and the status changes at that same edge.
- R3: Status bits 31:30 hold the state. An expiry in state 0 or state 1 sets status bit 31, so state 0 goes to 2 and state 1 goes to 3.
- R4: An expiry in state 2 sets status bit 30, which gives state 3.
- R5: An expiry in state 2 asserts the interrupt output when control bit 27 is 1. The interrupt then stays high until software writes a 1 to status bit 30.
- R6: The first expiry in state 3 is the final one. It copies control bits 29:28 into status bits 29:28. After it, further expiries change nothing, until a status write clears bit 31 or bit 30.
- R7: At the final expiry, control bits 29:28 choose the reset request: 0 gives none, 1 gives core, 2 gives chip and 3 gives system. At most one request is high at a time, and while a request is high the status shows state 3 with a non-zero recorded kind.
- R8: Each reset request is a pulse of exactly one clock cycle, seen in the cycle after the final expiry edge.
- R9: A status write clears each implemented status bit (31:28) written as 1 and leaves those written as 0. If an expiry sets a bit in the same cycle, the set wins. Clearing the status often enough keeps both the interrupt and the reset requests low.
- R10: The control readback returns the written bits 31:27, and zero in bits 26:0. The status readback is zero in bits 27:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_value | input | TB_W | Free-running timebase count |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_din | input | 32 | Control write data (bits 31:27 used) |
| ctl_dout | output | 32 | Control register readback |
| sts_wr | input | 1 | Status write-one-to-clear strobe |
| sts_din | input | 32 | Status clear mask (bits 31:28 used) |
| sts_dout | output | 32 | Status register readback |
| wd_irq | output | 1 | Watchdog interrupt, level |
| rst_core_req | output | 1 | Core reset request pulse |
| rst_chip_req | output | 1 | Chip reset request pulse |
| rst_sys_req | output | 1 | System reset request pulse |

## Verification
A wrong state would show up on the status readback at the first expiry edge that follows it. It would also skew the stage at which the interrupt or a reset request appears, by one whole period. A lost halt flag shows as a second reset pulse one period after the first. A wrong tap shows as an expiry that comes a power-of-two factor too early or too late. The bench keeps its own model of the progression and compares the status, the interrupt and the reset lines every cycle. It does this for every period code, every reset kind and both interrupt settings, and also during a run in which the watchdog is serviced.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    ST_QUIET = 2'b00,
    ST_HALF  = 2'b01,
    ST_ARMED = 2'b10,
    ST_LAST  = 2'b11
  } wd_state_t;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_CORE = 2'b01,
    KIND_CHIP = 2'b10,
    KIND_SYS  = 2'b11
  } rst_kind_t;

  localparam int NUM_KINDS = 3;
  localparam int NUM_CODES = 4;
  localparam int CODE_W    = 2;
endpackage

// File: rtl/wdg_tap.sv
module wdg_tap
  import wdg_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int PER_LOG0 = 17,
  parameter int PER_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TB_W-1:0]   tb,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  logic [NUM_CODES-1:0] taps;
  logic                 sel;
  logic                 prev_q;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tap
    localparam int IDX = PER_LOG0 - 1 + PER_STEP * g;
    assign taps[g] = tb[IDX];
  end

  assign sel = taps[code];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel;
  end

  assign hit = sel & ~prev_q;

  // R2: two expiries can never come in back-to-back cycles with a fixed code
  a_r2_hit_spacing: assert property (@(posedge clk) disable iff (rst)
    (hit && $stable(code)) |=> !hit);
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       irq_en,
  input  logic [1:0] kind_sel,
  input  logic       clr_we,
  input  logic [3:0] clr_mask,
  output logic [3:0] sts,
  output logic       irq,
  output logic       fire,
  output rst_kind_t  fire_kind
);
  logic [3:0] sts_q, sts_d;
  logic       halt_q, halt_d;
  logic       irq_q, irq_d;
  logic       live, irq_set;
  wd_state_t  st;

  assign st   = wd_state_t'(sts_q[3:2]);
  assign live = hit & ~halt_q;

  always_comb begin
    sts_d   = clr_we ? (sts_q & ~clr_mask) : sts_q;
    fire    = 1'b0;
    irq_set = 1'b0;
    if (live) begin
      case (st)
        ST_QUIET, ST_HALF: sts_d[3] = 1'b1;
        ST_ARMED: begin
          sts_d[2] = 1'b1;
          irq_set  = irq_en;
        end
        default: begin
          sts_d[1:0] = kind_sel;
          fire       = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    halt_d = halt_q;
    if (clr_we && (clr_mask[3] || clr_mask[2])) halt_d = 1'b0;
    if (fire) halt_d = 1'b1;
    irq_d = irq_q;
    if (clr_we && clr_mask[2]) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      halt_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      halt_q <= halt_d;
      irq_q  <= irq_d;
    end
  end

  assign sts       = sts_q;
  assign irq       = irq_q;
  assign fire_kind = rst_kind_t'(kind_sel);

  // R3: from state 0 one step can never reach state 3
  a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
    (st == ST_QUIET) |=> (sts_q[3:2] != 2'b11));
  // R5: the interrupt only rises as the state reaches 3
  a_r5_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (sts_q[3:2] == 2'b11));
  // R6: once halted, status holds unless software writes it
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !clr_we) |=> $stable(sts_q));
endmodule

// File: rtl/wdg_rst_out.sv
module wdg_rst_out
  import wdg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  rst_kind_t            kind,
  output logic [NUM_KINDS-1:0] pulse
);
  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_kind
    logic p_q;
    always_ff @(posedge clk) begin
      if (rst) p_q <= 1'b0;
      else     p_q <= fire && (kind == rst_kind_t'(g + 1));
    end
    assign pulse[g] = p_q;

    // R8: every request lasts one cycle only
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      p_q |=> !p_q);
  end

  // R7: never more than one request at once
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int PER_LOG0 = 17,
  parameter int PER_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tb_value,
  input  logic            ctl_wr,
  input  logic [31:0]     ctl_din,
  output logic [31:0]     ctl_dout,
  input  logic            sts_wr,
  input  logic [31:0]     sts_din,
  output logic [31:0]     sts_dout,
  output logic            wd_irq,
  output logic            rst_core_req,
  output logic            rst_chip_req,
  output logic            rst_sys_req
);
  localparam int CTL_BITS = 5;
  localparam int STS_BITS = 4;

  logic [CTL_BITS-1:0]  ctl_q;
  logic                 hit;
  logic [STS_BITS-1:0]  sts;
  logic                 fire;
  rst_kind_t            fire_kind;
  logic [NUM_KINDS-1:0] pulse;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_din[31:31-CTL_BITS+1];
  end

  wdg_tap #(
    .TB_W(TB_W), .PER_LOG0(PER_LOG0), .PER_STEP(PER_STEP)
  ) u_tap (
    .clk(clk), .rst(rst), .tb(tb_value), .code(ctl_q[4:3]), .hit(hit)
  );

  wdg_stage u_stage (
    .clk(clk), .rst(rst), .hit(hit),
    .irq_en(ctl_q[0]), .kind_sel(ctl_q[2:1]),
    .clr_we(sts_wr), .clr_mask(sts_din[31:28]),
    .sts(sts), .irq(wd_irq), .fire(fire), .fire_kind(fire_kind)
  );

  wdg_rst_out u_out (
    .clk(clk), .rst(rst), .fire(fire), .kind(fire_kind), .pulse(pulse)
  );

  assign rst_core_req = pulse[0];
  assign rst_chip_req = pulse[1];
  assign rst_sys_req  = pulse[2];
  assign ctl_dout     = {ctl_q, {(32-CTL_BITS){1'b0}}};
  assign sts_dout     = {sts, {(32-STS_BITS){1'b0}}};

  // R7: a request is seen only with state 3 and a recorded kind
  a_r7_recorded: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |-> (sts_dout[31:30] == 2'b11 && sts_dout[29:28] != 2'b00));
  // R7: the pulse matches the recorded kind
  a_r7_kind_match: assert property (@(posedge clk) disable iff (rst)
    rst_sys_req |-> (sts_dout[29:28] == 2'b11));
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_W = 12;
  localparam int PL0  = 3;
  localparam int STP  = 2;

  logic clk = 1'b0;
  logic rst;
  logic [TB_W-1:0] tb_value;
  logic ctl_wr, sts_wr;
  logic [31:0] ctl_din, sts_din, ctl_dout, sts_dout;
  logic wd_irq, rst_core_req, rst_chip_req, rst_sys_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_top #(.TB_W(TB_W), .PER_LOG0(PL0), .PER_STEP(STP)) u0 (
    .clk(clk), .rst(rst), .tb_value(tb_value),
    .ctl_wr(ctl_wr), .ctl_din(ctl_din), .ctl_dout(ctl_dout),
    .sts_wr(sts_wr), .sts_din(sts_din), .sts_dout(sts_dout),
    .wd_irq(wd_irq), .rst_core_req(rst_core_req),
    .rst_chip_req(rst_chip_req), .rst_sys_req(rst_sys_req)
  );

  int n_cmp = 0, n_bad = 0;
  int tbcnt = 0;
  logic [3:0] m_sts = 0;
  logic [4:0] m_ctl = 0;
  logic m_irq = 0, m_halt = 0, m_prev = 0;
  logic [2:0] m_rst = 0;
  int pulses = 0, irq_rises = 0;
  logic irq_seen = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic model_step(input int v, input logic cw, input logic [31:0] cd,
                            input logic sw, input logic [31:0] sd);
    int tap;
    logic bitv, hit, live, fire, iset;
    logic [3:0] nxt;
    tap  = PL0 - 1 + STP * int'(m_ctl[4:3]);
    bitv = ((v >> tap) & 1) != 0;
    hit  = bitv & ~m_prev;
    m_prev = bitv;
    live = hit & ~m_halt;
    nxt  = sw ? (m_sts & ~sd[31:28]) : m_sts;
    fire = 0; iset = 0; m_rst = 0;
    if (live) begin
      case (m_sts[3:2])
        2'b00, 2'b01: nxt[3] = 1'b1;
        2'b10: begin nxt[2] = 1'b1; iset = m_ctl[0]; end
        default: begin nxt[1:0] = m_ctl[2:1]; fire = 1'b1; end
      endcase
    end
    if (fire && m_ctl[2:1] != 0) m_rst = 3'b001 << (int'(m_ctl[2:1]) - 1);
    if (sw && (sd[31] || sd[30])) m_halt = 0;
    if (fire) m_halt = 1;
    if (sw && sd[30]) m_irq = 0;
    if (iset) m_irq = 1;
    m_sts = nxt;
    if (cw) m_ctl = cd[31:27];
  endtask

  task automatic cyc(input logic cw, input logic [31:0] cd, input logic sw, input logic [31:0] sd);
    tb_value = tbcnt[TB_W-1:0];
    ctl_wr = cw; ctl_din = cd; sts_wr = sw; sts_din = sd;
    @(posedge clk);
    model_step(tbcnt, cw, cd, sw, sd);
    tbcnt = (tbcnt + 1) % (1 << TB_W);
    @(negedge clk);
    ctl_wr = 0; sts_wr = 0; ctl_din = 0; sts_din = 0;
    check("R2 R3 R4 R6 R9 status", sts_dout, {m_sts, 28'b0});
    check("R5 irq", {31'b0, wd_irq}, {31'b0, m_irq});
    check("R7 R8 reset", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, {29'b0, m_rst});
    pulses += int'(rst_core_req) + int'(rst_chip_req) + int'(rst_sys_req);
    if (wd_irq && !irq_seen) irq_rises++;
    irq_seen = wd_irq;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_all();
  end

  initial begin
    rst = 1; tb_value = 0; ctl_wr = 0; sts_wr = 0; ctl_din = 0; sts_din = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", sts_dout, 0);
    check("R1 control", ctl_dout, 0);
    check("R1 outputs", {28'b0, wd_irq, rst_core_req, rst_chip_req, rst_sys_req}, 0);
    rst = 0;

    for (int code = 0; code < 4; code++)
      for (int kind = 0; kind < 4; kind++)
        for (int ie = 0; ie < 2; ie++) begin
          logic [31:0] cv;
          cv = {code[1:0], kind[1:0], ie[0], 27'b0};
          cyc(1, cv, 1, 32'hFFFF_FFFF);
          pulses = 0; irq_rises = 0;
          // R10 readback
          check("R10 control readback", ctl_dout, cv);
          for (int n = 0; n < 4 * (1 << (PL0 + STP * code)) + 8; n++) cyc(0, 0, 0, 0);
          check("R7 R8 R6 pulse count", pulses, (kind != 0) ? 1 : 0);
          check("R5 irq count", irq_rises, ie);
          check("R6 final state", {30'b0, sts_dout[31:30]}, 3);
          check("R6 recorded kind", {30'b0, sts_dout[29:28]}, kind);
        end

    // R9 servicing keeps the watchdog quiet
    cyc(1, {2'd0, 2'd3, 1'b1, 27'b0}, 1, 32'hF000_0000);
    pulses = 0; irq_rises = 0;
    for (int n = 0; n < 400; n++) begin
      if (n % 6 == 5)      cyc(0, 0, 1, 32'hC000_0000);
      else if (n % 6 == 2) cyc(0, 0, 1, 32'h0000_0000);
      else                 cyc(0, 0, 0, 0);
    end
    check("R9 service no reset", pulses, 0);
    check("R9 service no irq", irq_rises, 0);
    finish_all();
  end
endmodule